// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a device's start-up configuration from a byte-addressed serial EEPROM. It runs once after reset. It runs again when the soft-reset input pulses, or when software asks for a reload while the block is idle. The block fetches the image one byte at a time through a request/response port to an external EEPROM controller. The image has three sections, each opened by a marker byte of 0xA5. The first section is the 48-bit station address, the second is the 32-bit configuration strap word, and the third is a counted list of register-write bursts. The bursts are sent out through a CSR write port.

A section whose marker is wrong ends the load at that point, and every later section is skipped. A read error, or a controller that stops answering, also ends the load and raises an error flag. While the load runs, `busy` is high and `ready` is low. The two flags swap in the same cycle when the load ends.

Both data ports use valid/ready. The read request, once valid, keeps its address stable until the controller accepts it. Only one read is outstanding at a time. `rd_rsp_ready` is high only while a response is awaited. A CSR write, once valid, keeps its address and data stable until `csr_ready` is seen. The loader waits for as long as either side holds back, up to the timeout described below.

Top module: `cfg_image_loader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `busy`=1, `ready`=0 and `load_err`=0. `station_addr` and `strap_word` hold their parameter defaults, and a load from address 0 begins.
- R2: A `reload_req` pulse while `busy`=0 starts a load: `busy` is 1 in the next cycle, `load_err` is cleared, and both outputs return to their defaults.
- R3: A `reload_req` while `busy`=1 has no effect: address 0 is not read again and the running load completes unchanged.
- R4: A `soft_rst` pulse at any time abandons the current load and starts over from address 0. The outputs return to their defaults in the next cycle.
- R5: If byte 0 is 0xA5, bytes 1..6 form `station_addr`, where byte k goes to bits [8k-1:8k-8]. Any other value ends the load after that single read.
- R6: If byte 7 is 0xA5, bytes 8..11 form `strap_word`, least significant byte first. Any other value ends the load after 8 reads, leaving `strap_word` at its default.
- R7: If byte 12 is 0xA5, byte 13 is the burst count N. Each burst is made of: a 16-bit start word address (low byte first), an 8-bit word count M, then M little-endian 32-bit words. The words are written to consecutive CSR addresses starting at the start address.
- R8: N=0 ends the load right after byte 13, with no CSR write. A burst with M=0 writes nothing, and the next burst header follows immediately.
- R9: A CSR write stays valid with stable address and data until accepted, and the bench sees the same writes under back-pressure as without it.
- R10: A read request stays valid with stable address until accepted, and no new request is made while a response is awaited.
- R11: A response flagged as an error ends the load: `load_err`=1, `busy`=0 and `ready`=1. A value from a section that was not finished is not committed.
- R12: If a read is not completed within TIMEOUT_CYCLES, the load ends exactly as in R11.
- R13: `ready` is always the complement of `busy`. When a load ends, `busy` falls and `ready` rises on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (pin or power-on) |
| soft_rst | input | 1 | Digital soft-reset pulse, restarts the load |
| reload_req | input | 1 | Software reload command pulse |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Controller accepts the request |
| rd_req_addr | output | AW | EEPROM byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader awaits a response |
| rd_rsp_data | input | 8 | Byte read |
| rd_rsp_err | input | 1 | Response carries a read error |
| csr_valid | output | 1 | CSR write valid |
| csr_ready | input | 1 | CSR write accepted |
| csr_addr | output | 16 | CSR word address |
| csr_data | output | 32 | CSR write data |
| station_addr | output | 48 | Loaded station address |
| strap_word | output | 32 | Loaded configuration strap word |
| busy | output | 1 | Load in progress |
| ready | output | 1 | Device ready (no load active) |
| load_err | output | 1 | Last load ended on a read error or timeout |

## Verification
A reload or soft reset taken at one clock edge shows up as `busy`=1 and default outputs after that same edge. The bench therefore pulses the input for one cycle and samples at the next falling edge. The first read request appears two edges after the load starts. Each later request appears two edges after the previous response is consumed. The completion flags, and the committed address or strap value, change on the edge that consumes the last byte or the last CSR acceptance. The bench drives its memory and CSR models on falling edges and records each handshake in the half cycle before the edge that completes it. It compares final values only once `busy` has been seen low, and it compares the order of writes and reads rather than absolute cycle counts. This keeps every check valid under the stall patterns.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam logic [7:0] SECTION_MARK = 8'hA5;

  typedef enum logic [3:0] {
    PH_MARK_ID, PH_STATION, PH_MARK_STRAP, PH_STRAP,
    PH_MARK_BURST, PH_NBURST, PH_BADDR, PH_BCNT, PH_BDATA
  } phase_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_WRITE} sq_state_t;
  typedef enum logic [1:0] {BF_IDLE, BF_REQ, BF_WAIT} bf_state_t;
endpackage

// File: rtl/eel_byte_fetch.sv
module eel_byte_fetch
  import eel_pkg::*;
#(
  parameter int AW = 11,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_err,
  output logic          got,
  output logic [7:0]    got_data,
  output logic          fail
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  bf_state_t     st;
  logic [TW-1:0] tmr;
  logic [AW-1:0] addr_q;
  logic          expired;

  assign expired   = (st != BF_IDLE) && (tmr == TW'(TIMEOUT_CYCLES));
  assign req_valid = (st == BF_REQ);
  assign req_addr  = addr_q;
  assign rsp_ready = (st == BF_WAIT);
  assign got       = (st == BF_WAIT) && rsp_valid && !rsp_err;
  assign got_data  = rsp_data;
  assign fail      = ((st == BF_WAIT) && rsp_valid && rsp_err) || expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= BF_IDLE;
      tmr    <= '0;
      addr_q <= '0;
    end else if (abort) begin
      st  <= BF_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        BF_IDLE: if (go) begin
          addr_q <= go_addr;
          tmr    <= '0;
          st     <= BF_REQ;
        end
        BF_REQ: begin
          tmr <= tmr + 1'b1;
          if (expired)        st <= BF_IDLE;
          else if (req_ready) st <= BF_WAIT;
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (expired || rsp_valid) st <= BF_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/eel_sequencer.sv
module eel_sequencer
  import eel_pkg::*;
#(
  parameter int          AW          = 11,
  parameter logic [47:0] DEF_STATION = 48'h0,
  parameter logic [31:0] DEF_STRAP   = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          reload_req,
  output logic          fetch_go,
  output logic [AW-1:0] fetch_addr,
  input  logic          got,
  input  logic [7:0]    got_data,
  input  logic          fail,
  output logic          csr_valid,
  input  logic          csr_ready,
  output logic [15:0]   csr_addr,
  output logic [31:0]   csr_data,
  output logic [47:0]   station_addr,
  output logic [31:0]   strap_word,
  output logic          busy,
  output logic          ready,
  output logic          load_err
);
  sq_state_t     st;
  phase_t        ph;
  logic [AW-1:0] ptr;
  logic [2:0]    sub;
  logic [7:0]    bursts_left, words_left;
  logic [15:0]   csr_ptr;
  logic [31:0]   word_acc;
  logic [39:0]   station_acc;
  logic          start;
  logic [7:0]    b;

  assign start      = soft_rst || (reload_req && !busy);
  assign fetch_go   = (st == SQ_ISSUE);
  assign fetch_addr = ptr;
  assign csr_valid  = (st == SQ_WRITE);
  assign csr_addr   = csr_ptr;
  assign csr_data   = word_acc;
  assign b          = got_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_ISSUE; ph <= PH_MARK_ID; ptr <= '0; sub <= '0;
      bursts_left <= '0; words_left <= '0; csr_ptr <= '0;
      word_acc <= '0; station_acc <= '0;
      station_addr <= DEF_STATION; strap_word <= DEF_STRAP;
      busy <= 1'b1; ready <= 1'b0; load_err <= 1'b0;
    end else if (start) begin
      st <= SQ_ISSUE; ph <= PH_MARK_ID; ptr <= '0; sub <= '0;
      station_addr <= DEF_STATION; strap_word <= DEF_STRAP;
      busy <= 1'b1; ready <= 1'b0; load_err <= 1'b0;
    end else begin
      case (st)
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (fail) begin
          st <= SQ_IDLE; busy <= 1'b0; ready <= 1'b1; load_err <= 1'b1;
        end else if (got) begin
          ptr <= ptr + 1'b1;
          st  <= SQ_ISSUE;
          case (ph)
            PH_MARK_ID, PH_MARK_STRAP, PH_MARK_BURST: begin
              sub <= '0;
              if (b == SECTION_MARK) begin
                if (ph == PH_MARK_ID)         ph <= PH_STATION;
                else if (ph == PH_MARK_STRAP) ph <= PH_STRAP;
                else                          ph <= PH_NBURST;
              end else begin
                st <= SQ_IDLE; busy <= 1'b0; ready <= 1'b1;
              end
            end
            PH_STATION: if (sub == 3'd5) begin
              station_addr <= {b, station_acc};
              ph <= PH_MARK_STRAP;
            end else begin
              station_acc[{sub, 3'b000} +: 8] <= b;
              sub <= sub + 1'b1;
            end
            PH_STRAP: if (sub == 3'd3) begin
              strap_word <= {b, word_acc[23:0]};
              ph <= PH_MARK_BURST;
            end else begin
              word_acc[{sub[1:0], 3'b000} +: 8] <= b;
              sub <= sub + 1'b1;
            end
            PH_NBURST: begin
              bursts_left <= b;
              sub <= '0;
              if (b == 8'd0) begin
                st <= SQ_IDLE; busy <= 1'b0; ready <= 1'b1;
              end else ph <= PH_BADDR;
            end
            PH_BADDR: if (sub == 3'd0) begin
              csr_ptr[7:0] <= b; sub <= 3'd1;
            end else begin
              csr_ptr[15:8] <= b; ph <= PH_BCNT;
            end
            PH_BCNT: begin
              words_left <= b;
              sub <= '0;
              if (b != 8'd0) ph <= PH_BDATA;
              else if (bursts_left == 8'd1) begin
                st <= SQ_IDLE; busy <= 1'b0; ready <= 1'b1;
              end else begin
                bursts_left <= bursts_left - 1'b1; ph <= PH_BADDR;
              end
            end
            default: begin
              word_acc[{sub[1:0], 3'b000} +: 8] <= b;
              if (sub == 3'd3) st <= SQ_WRITE;
              else             sub <= sub + 1'b1;
            end
          endcase
        end
        SQ_WRITE: if (csr_ready) begin
          csr_ptr <= csr_ptr + 16'd1;
          sub <= '0;
          if (words_left != 8'd1) begin
            words_left <= words_left - 1'b1; st <= SQ_ISSUE;
          end else if (bursts_left == 8'd1) begin
            st <= SQ_IDLE; busy <= 1'b0; ready <= 1'b1;
          end else begin
            bursts_left <= bursts_left - 1'b1; ph <= PH_BADDR; st <= SQ_ISSUE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int          AW             = 11,
  parameter int          TIMEOUT_CYCLES = 256,
  parameter logic [47:0] DEF_STATION    = 48'h0200_0000_0001,
  parameter logic [31:0] DEF_STRAP      = 32'h0000_0F0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          reload_req,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [7:0]    rd_rsp_data,
  input  logic          rd_rsp_err,
  output logic          csr_valid,
  input  logic          csr_ready,
  output logic [15:0]   csr_addr,
  output logic [31:0]   csr_data,
  output logic [47:0]   station_addr,
  output logic [31:0]   strap_word,
  output logic          busy,
  output logic          ready,
  output logic          load_err
);
  logic          fetch_go, got, fail;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    got_data;

  eel_byte_fetch #(.AW(AW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fetch (
    .clk(clk), .rst_n(rst_n), .abort(soft_rst),
    .go(fetch_go), .go_addr(fetch_addr),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_ready(rd_rsp_ready),
    .rsp_data(rd_rsp_data), .rsp_err(rd_rsp_err),
    .got(got), .got_data(got_data), .fail(fail)
  );

  eel_sequencer #(.AW(AW), .DEF_STATION(DEF_STATION), .DEF_STRAP(DEF_STRAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reload_req(reload_req),
    .fetch_go(fetch_go), .fetch_addr(fetch_addr),
    .got(got), .got_data(got_data), .fail(fail),
    .csr_valid(csr_valid), .csr_ready(csr_ready),
    .csr_addr(csr_addr), .csr_data(csr_data),
    .station_addr(station_addr), .strap_word(strap_word),
    .busy(busy), .ready(ready), .load_err(load_err)
  );
endmodule

// File: rtl/eel_loader_chk.sv
module eel_loader_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          reload_req,
  input logic          busy,
  input logic          ready,
  input logic          load_err,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_rsp_ready,
  input logic          csr_valid,
  input logic          csr_ready,
  input logic [15:0]   csr_addr,
  input logic [31:0]   csr_data
);
  p_ready_not_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ready == !busy);

  p_reload_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reload_req) |=> busy);

  p_soft_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (busy && !load_err));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !soft_rst) |=>
      ((rd_req_valid && $stable(rd_req_addr)) || load_err));

  p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  p_csr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && !csr_ready && !soft_rst) |=>
      (csr_valid && $stable(csr_addr) && $stable(csr_data)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !csr_valid));

  p_err_ends_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> !busy);
endmodule

bind cfg_image_loader eel_loader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reload_req(reload_req),
  .busy(busy), .ready(ready), .load_err(load_err),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_ready(rd_rsp_ready), .csr_valid(csr_valid), .csr_ready(csr_ready),
  .csr_addr(csr_addr), .csr_data(csr_data)
);

// File: tb/tb_cfg_image_loader.sv
`timescale 1ns/1ps
module tb_cfg_image_loader;
  localparam int AW = 11;
  localparam logic [47:0] DEF_ST = 48'h0200_0000_0001;
  localparam logic [31:0] DEF_SP = 32'h0000_0F0F;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, reload_req = 1'b0;
  logic rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr;
  logic [7:0] rd_rsp_data = 8'h0;
  logic rd_rsp_err = 1'b0, csr_valid, csr_ready = 1'b0;
  logic [15:0] csr_addr;
  logic [31:0] csr_data, strap_word;
  logic [47:0] station_addr;
  logic busy, ready, load_err;

  always #2 clk = ~clk;

  cfg_image_loader dut (.*);

  logic [7:0] img [0:63];
  int checks = 0, fails = 0;
  int reads = 0, zero_reads = 0, nlog = 0;
  logic [15:0] log_a [0:15];
  logic [31:0] log_d [0:15];
  bit pending = 0, rsp_drop = 0, mute = 0, stall = 0, cstall = 0, tog = 0;
  int paddr = 0, cd = 0, lat = 1, err_addr = -1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory and CSR sink models, stepped on falling edges
  initial forever begin
    @(negedge clk);
    if (rsp_drop) begin rd_rsp_valid = 0; rd_rsp_err = 0; rsp_drop = 0; pending = 0; end
    if (pending && !rd_rsp_valid && !mute) begin
      if (cd > 1) cd--;
      else begin
        rd_rsp_valid = 1; rd_rsp_data = img[paddr[5:0]]; rd_rsp_err = (paddr == err_addr);
      end
    end
    if (rd_rsp_valid && rd_rsp_ready) rsp_drop = 1;
    tog = ~tog;
    rd_req_ready = stall ? tog : 1'b1;
    if (rd_req_valid && rd_req_ready && !pending) begin
      pending = 1; paddr = int'(rd_req_addr); cd = lat; reads++;
      if (rd_req_addr == '0) zero_reads++;
    end
    csr_ready = cstall ? ~tog : 1'b1;
    if (csr_valid && csr_ready && nlog < 16) begin
      log_a[nlog] = csr_addr; log_d[nlog] = csr_data; nlog++;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic clear_model();
    pending = 0; rsp_drop = 0; rd_rsp_valid = 0; rd_rsp_err = 0;
    reads = 0; zero_reads = 0; nlog = 0;
  endtask

  task automatic build_full(input logic [7:0] nb);
    for (int i = 0; i < 64; i++) img[i] = 8'h00;
    img[0] = 8'hA5;
    img[1] = 8'h02; img[2] = 8'h11; img[3] = 8'h22; img[4] = 8'h33; img[5] = 8'h44; img[6] = 8'h55;
    img[7] = 8'hA5;
    img[8] = 8'h78; img[9] = 8'h56; img[10] = 8'h34; img[11] = 8'h12;
    img[12] = 8'hA5; img[13] = nb;
    img[14] = 8'h40; img[15] = 8'h00; img[16] = 8'h02;
    img[17] = 8'hD4; img[18] = 8'hC3; img[19] = 8'hB2; img[20] = 8'hA1;
    img[21] = 8'h0D; img[22] = 8'hF0; img[23] = 8'hAD; img[24] = 8'h0B;
    img[25] = 8'h00; img[26] = 8'h01; img[27] = 8'h00;
    img[28] = 8'hF0; img[29] = 8'h01; img[30] = 8'h01;
    img[31] = 8'h0D; img[32] = 8'hF0; img[33] = 8'hFE; img[34] = 8'hCA;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (!busy) break;
      tick();
    end
  endtask

  task automatic pulse_reload();
    tick(); reload_req = 1; tick(); reload_req = 0;
  endtask

  task automatic check_full(input string tag);
    chk(station_addr == 48'h5544_3322_1102, {tag, " R5 station"}, station_addr, 48'h5544_3322_1102);
    chk(strap_word == 32'h1234_5678, {tag, " R6 strap"}, strap_word, 32'h1234_5678);
    chk(nlog == 3, {tag, " R7 csr write count"}, nlog, 3);
    chk(log_a[0] == 16'h0040 && log_d[0] == 32'hA1B2_C3D4, {tag, " R7 write0"}, {log_a[0], log_d[0]}, {16'h0040, 32'hA1B2_C3D4});
    chk(log_a[1] == 16'h0041 && log_d[1] == 32'h0BAD_F00D, {tag, " R7 write1"}, {log_a[1], log_d[1]}, {16'h0041, 32'h0BAD_F00D});
    chk(log_a[2] == 16'h01F0 && log_d[2] == 32'hCAFE_F00D, {tag, " R8 write after empty burst"}, {log_a[2], log_d[2]}, {16'h01F0, 32'hCAFE_F00D});
    chk(reads == 35, {tag, " R10 read count"}, reads, 35);
    chk(!busy && ready && !load_err, {tag, " R13 done flags"}, {busy, ready, load_err}, 3'b010);
  endtask

  task automatic t_power_on();
    build_full(8'd3);
    tick();
    chk(busy && !ready && !load_err, "R1 flags in reset", {busy, ready, load_err}, 3'b100);
    chk(station_addr == DEF_ST, "R1 default station", station_addr, DEF_ST);
    rst_n = 1; tick();
    chk(busy && !ready, "R1 busy after release", {busy, ready}, 2'b10);
    wait_idle();
    check_full("power-on");
  endtask

  task automatic t_bad_id();
    build_full(8'd3); img[0] = 8'h5A; clear_model();
    pulse_reload();
    chk(busy && !ready && station_addr == DEF_ST, "R2 reload starts", {busy, ready}, 2'b10);
    wait_idle();
    chk(station_addr == DEF_ST && strap_word == DEF_SP, "R5 bad marker keeps defaults", station_addr, DEF_ST);
    chk(reads == 1 && nlog == 0, "R5 single read", reads, 1);
  endtask

  task automatic t_bad_strap();
    build_full(8'd3); img[7] = 8'h00; clear_model();
    pulse_reload(); wait_idle();
    chk(station_addr == 48'h5544_3322_1102, "R6 station kept", station_addr, 48'h5544_3322_1102);
    chk(strap_word == DEF_SP && reads == 8, "R6 strap default, 8 reads", {strap_word, reads[7:0]}, {DEF_SP, 8'd8});
  endtask

  task automatic t_zero_bursts();
    build_full(8'd0); clear_model();
    pulse_reload(); wait_idle();
    chk(reads == 14 && nlog == 0, "R8 zero bursts", {reads[7:0], nlog[7:0]}, {8'd14, 8'd0});
    chk(strap_word == 32'h1234_5678 && ready, "R8 strap with zero bursts", strap_word, 32'h1234_5678);
  endtask

  task automatic t_backpressure();
    build_full(8'd3); clear_model(); stall = 1; cstall = 1; lat = 3;
    pulse_reload(); wait_idle();
    check_full("R9 stalled");
    stall = 0; cstall = 0; lat = 1;
  endtask

  task automatic t_read_err();
    build_full(8'd3); clear_model(); err_addr = 9;
    pulse_reload(); wait_idle();
    chk(load_err && !busy && ready, "R11 error flags", {busy, ready, load_err}, 3'b011);
    chk(strap_word == DEF_SP && reads == 10, "R11 strap not committed", strap_word, DEF_SP);
    err_addr = -1;
  endtask

  task automatic t_timeout();
    build_full(8'd3); clear_model(); mute = 1;
    pulse_reload();
    chk(!load_err, "R2 error cleared on reload", load_err, 0);
    wait_idle();
    chk(load_err && ready && station_addr == DEF_ST, "R12 timeout", {ready, load_err}, 2'b11);
    mute = 0;
  endtask

  task automatic t_reload_busy();
    build_full(8'd3); clear_model();
    pulse_reload();
    repeat (10) tick();
    reload_req = 1; tick(); reload_req = 0;
    wait_idle();
    chk(zero_reads == 1, "R3 reload while busy ignored", zero_reads, 1);
    check_full("R3");
  endtask

  task automatic t_soft_rst();
    build_full(8'd3); clear_model();
    pulse_reload();
    repeat (50) tick();
    soft_rst = 1; clear_model(); rd_req_ready = 0; csr_ready = 0;
    tick(); soft_rst = 0;
    chk(busy && station_addr == DEF_ST && strap_word == DEF_SP, "R4 soft reset defaults", station_addr, DEF_ST);
    wait_idle();
    chk(zero_reads == 1, "R4 restart from address 0", zero_reads, 1);
    check_full("R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_power_on();
    t_bad_id();
    t_bad_strap();
    t_zero_bursts();
    t_backpressure();
    t_read_err();
    t_timeout();
    t_reload_busy();
    t_soft_rst();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule